// File: doc/BRIEF.md
# Main Clock Frequency Meter

This block measures how fast a main clock runs by comparing it with a slow reference clock of about 32 kHz. The slow domain opens a gate that lasts exactly sixteen slow-clock periods. The gate level crosses into the main domain through a two-flop synchronizer, and a counter there counts every main-clock edge on which the synchronized gate is high. When the gate closes, the count is written to a read-only result field. One main cycle later a ready flag is raised.

Software pulses a start bit in the main domain to request a measurement. It then polls the ready flag and reads the result only after the flag is set. Releasing reset also starts a measurement, so the first value is available without a request. A start that arrives while a gate is open abandons that gate and runs a complete new one. Each gate carries a generation bit, so a stale gate from an earlier request is never counted.

Top module: `meas_top`

## Requirements
- R1: While reset is asserted, and on the first main cycles after release, `ready` is 0 and `result` is all zeros.
- R2: After reset is released, a measurement runs without any start pulse. `ready` rises with `result` equal to that window's count. `ready` is never high while counting is in progress.
- R3: The measurement window is exactly WIN_LEN (16) slow-clock periods long. With a slow period of k main periods, `result` equals 16*k.
- R4: The count saturates at all ones (2^CNT_W - 1) and does not wrap. If 16*k exceeds that value, `result` reads all ones.
- R5: A one-cycle high pulse on `start` drives `ready` to 0 at the next main edge. `result` keeps its previous value until the new measurement completes.
- R6: While `ready` is high and `start` is low, `result` does not change.
- R7: `result` takes its final value at least one main cycle before `ready` rises. At the first cycle `ready` is seen high, `result` already holds the complete count.
- R8: A start issued while a window is open discards the partial count. The next ready reports a full 16-period window.
- R9: If the main clock stops after a start, `ready` stays 0 and `result` keeps the previous count, even after the main clock runs again without a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_main | input | 1 | Main clock being measured; also the register-side clock |
| clk_slow | input | 1 | Slow reference clock (about 32 kHz) |
| rst_n | input | 1 | Asynchronous active-low reset; synchronized separately into each domain |
| start | input | 1 | One-cycle pulse in the main domain that requests a new measurement |
| result | output | CNT_W (16) | Last completed count of main edges per window, saturating |
| ready | output | 1 | High when `result` holds a completed count |

## Verification
The hardest case to reach is a measurement interrupted by a stopped main clock. Software must issue a start, and the main clock must then freeze before the slow domain runs the whole window. The bench halts its own main clock at a low phase right after the start pulse is registered. It keeps the slow clock running for many window lengths, then restarts the main clock and checks that neither the flag nor the old count moved. It also sweeps the slow period over many integer ratios, with edges offset by a fixed phase so that each expected count is exact. That sweep covers the exact-count region and the saturation region of an 8-bit result.

// File: rtl/meas_pkg.sv
`timescale 1ns/1ps
package meas_pkg;

  typedef enum logic [1:0] {
    SG_IDLE = 2'd0,
    SG_ARM  = 2'd1,
    SG_GATE = 2'd2
  } slow_st_e;

  typedef enum logic [1:0] {
    MC_WAIT  = 2'd0,
    MC_COUNT = 2'd1,
    MC_PUB   = 2'd2,
    MC_DONE  = 2'd3
  } main_st_e;

  // Width of an index that can hold values 0 .. n-1 (at least one bit).
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/meas_rst_sync.sv
`timescale 1ns/1ps
module meas_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/meas_cdc_sync.sv
`timescale 1ns/1ps
module meas_cdc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/meas_slow_gate.sv
`timescale 1ns/1ps
module meas_slow_gate
  import meas_pkg::*;
#(
  parameter int WIN_LEN = 16,
  parameter int SLOT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_s,
  output logic              win_o,
  output logic              gen_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              pend_o
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(WIN_LEN - 1);

  slow_st_e          st_q;
  logic              win_q;
  logic              gen_q;
  logic [SLOT_W-1:0] slot_q;
  logic              pend;

  // A request is pending while the synchronized toggle differs from the
  // generation of the window last armed.
  assign pend = (req_s != gen_q);

  // The generation bit changes only on entry to SG_ARM, where the gate is low
  // for at least one slow period, so it is settled before the gate rises.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SG_IDLE;
      win_q  <= 1'b0;
      gen_q  <= 1'b1;
      slot_q <= '0;
    end else begin
      unique case (st_q)
        SG_IDLE: begin
          if (pend) begin
            st_q  <= SG_ARM;
            gen_q <= req_s;
          end
        end
        SG_ARM: begin
          if (pend) begin
            gen_q <= req_s;
          end else begin
            st_q   <= SG_GATE;
            win_q  <= 1'b1;
            slot_q <= '0;
          end
        end
        SG_GATE: begin
          if (pend) begin
            st_q  <= SG_ARM;
            gen_q <= req_s;
            win_q <= 1'b0;
          end else if (slot_q == LAST_SLOT) begin
            st_q  <= SG_IDLE;
            win_q <= 1'b0;
          end else begin
            slot_q <= slot_q + 1'b1;
          end
        end
        default: begin
          st_q  <= SG_IDLE;
          win_q <= 1'b0;
        end
      endcase
    end
  end

  assign win_o  = win_q;
  assign gen_o  = gen_q;
  assign slot_o = slot_q;
  assign pend_o = pend;
endmodule

// File: rtl/meas_main_count.sv
`timescale 1ns/1ps
module meas_main_count
  import meas_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             win_s,
  input  logic             gen_s,
  output logic             req_o,
  output logic [CNT_W-1:0] result_o,
  output logic             ready_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             count_en_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // Increment that sticks at the top value instead of wrapping.
  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? CNT_MAX : v + 1'b1;
  endfunction

  main_st_e         st_q;
  logic             tgl_q;
  logic             win_prev_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] result_q;
  logic             ready_q;
  logic             open_edge;
  logic             count_en;

  // A window opens for this request only if its generation matches.
  assign open_edge = win_s && !win_prev_q && (gen_s == tgl_q);
  assign count_en  = (st_q == MC_COUNT) && win_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= MC_WAIT;
      tgl_q      <= 1'b0;
      win_prev_q <= 1'b0;
      cnt_q      <= '0;
      result_q   <= '0;
      ready_q    <= 1'b0;
    end else begin
      win_prev_q <= win_s;
      if (start_i) begin
        tgl_q   <= ~tgl_q;
        cnt_q   <= '0;
        ready_q <= 1'b0;
        st_q    <= MC_WAIT;
      end else begin
        unique case (st_q)
          MC_WAIT: begin
            if (open_edge) begin
              cnt_q <= sat_inc('0);
              st_q  <= MC_COUNT;
            end
          end
          MC_COUNT: begin
            if (win_s) begin
              cnt_q <= sat_inc(cnt_q);
            end else begin
              result_q <= cnt_q;
              st_q     <= MC_PUB;
            end
          end
          MC_PUB: begin
            ready_q <= 1'b1;
            st_q    <= MC_DONE;
          end
          default: begin
            st_q <= MC_DONE;
          end
        endcase
      end
    end
  end

  assign req_o      = tgl_q;
  assign result_o   = result_q;
  assign ready_o    = ready_q;
  assign cnt_o      = cnt_q;
  assign count_en_o = count_en;
endmodule

// File: rtl/meas_top.sv
`timescale 1ns/1ps
module meas_top
  import meas_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int WIN_LEN     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_main,
  input  logic             clk_slow,
  input  logic             rst_n,
  input  logic             start,
  output logic [CNT_W-1:0] result,
  output logic             ready
);
  localparam int SLOT_W = idx_width(WIN_LEN);

  // Named internal events, used by the bound checker.
  logic              rst_m_n;
  logic              rst_s_n;
  logic              req_tgl;
  logic              req_s;
  logic              win_lvl;
  logic              win_gen;
  logic [SLOT_W-1:0] slot;
  logic              slow_pend;
  logic [1:0]        gate_s;
  logic [CNT_W-1:0]  cnt;
  logic              count_en;

  meas_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_main (
    .clk(clk_main), .rst_n(rst_n), .rst_n_o(rst_m_n)
  );

  meas_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_slow (
    .clk(clk_slow), .rst_n(rst_n), .rst_n_o(rst_s_n)
  );

  meas_cdc_sync #(.W(1), .STAGES(SYNC_STAGES)) u_req_sync (
    .clk(clk_slow), .rst_n(rst_s_n), .d(req_tgl), .q(req_s)
  );

  meas_slow_gate #(.WIN_LEN(WIN_LEN), .SLOT_W(SLOT_W)) u_gate (
    .clk(clk_slow), .rst_n(rst_s_n), .req_s(req_s),
    .win_o(win_lvl), .gen_o(win_gen), .slot_o(slot), .pend_o(slow_pend)
  );

  meas_cdc_sync #(.W(2), .STAGES(SYNC_STAGES)) u_gate_sync (
    .clk(clk_main), .rst_n(rst_m_n), .d({win_gen, win_lvl}), .q(gate_s)
  );

  meas_main_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk_main), .rst_n(rst_m_n), .start_i(start),
    .win_s(gate_s[0]), .gen_s(gate_s[1]),
    .req_o(req_tgl), .result_o(result), .ready_o(ready),
    .cnt_o(cnt), .count_en_o(count_en)
  );
endmodule

// File: rtl/meas_chk.sv
`timescale 1ns/1ps
module meas_chk #(
  parameter int CNT_W   = 16,
  parameter int WIN_LEN = 16,
  parameter int SLOT_W  = 4
) (
  input logic              clk_main,
  input logic              clk_slow,
  input logic              rst_m_n,
  input logic              rst_s_n,
  input logic              start,
  input logic              ready,
  input logic [CNT_W-1:0]  result,
  input logic [CNT_W-1:0]  cnt,
  input logic              count_en,
  input logic              win_lvl,
  input logic [SLOT_W-1:0] slot,
  input logic              slow_pend
);
  localparam logic [CNT_W-1:0]  TOP  = {CNT_W{1'b1}};
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(WIN_LEN - 1);

  // R2: the flag is never up while counting is still going on.
  assert_ready_not_counting_R2: assert property (
    @(posedge clk_main) disable iff (!rst_m_n) ready |-> !count_en);

  // R3: the gate closes only after its last slot or on an abandoned window.
  assert_window_length_R3: assert property (
    @(posedge clk_slow) disable iff (!rst_s_n)
    $fell(win_lvl) |-> ($past(slot) == LAST || $past(slow_pend)));

  // R4: a full counter stays full while counting continues.
  assert_no_overflow_R4: assert property (
    @(posedge clk_main) disable iff (!rst_m_n)
    (count_en && !start && cnt == TOP) |=> (cnt == TOP));

  // R5: a start pulse clears the flag at the next edge.
  assert_start_clears_ready_R5: assert property (
    @(posedge clk_main) disable iff (!rst_m_n) start |=> !ready);

  // R6: a published result is held while the flag stays up.
  assert_result_held_R6: assert property (
    @(posedge clk_main) disable iff (!rst_m_n)
    (ready && !start) |=> $stable(result));

  // R7: the result has already settled on the cycle the flag rises.
  assert_result_before_ready_R7: assert property (
    @(posedge clk_main) disable iff (!rst_m_n) $rose(ready) |-> $stable(result));
endmodule

bind meas_top meas_chk #(.CNT_W(CNT_W), .WIN_LEN(WIN_LEN), .SLOT_W(SLOT_W)) u_chk (
  .clk_main(clk_main), .clk_slow(clk_slow), .rst_m_n(rst_m_n), .rst_s_n(rst_s_n),
  .start(start), .ready(ready), .result(result), .cnt(cnt), .count_en(count_en),
  .win_lvl(win_lvl), .slot(slot), .slow_pend(slow_pend)
);

// File: tb/meas_top_tb.sv
`timescale 1ns/1ps
module meas_top_tb;
  localparam int CW   = 8;
  localparam int WIN  = 16;
  localparam int TOPV = (1 << CW) - 1;

  logic          clk_main = 1'b0;
  logic          clk_slow = 1'b0;
  logic          rst_n    = 1'b0;
  logic          start    = 1'b0;
  logic [CW-1:0] result;
  logic          ready;
  logic          clk_run  = 1'b1;
  int            kdiv     = 4;
  int            n_cmp    = 0;
  int            n_bad    = 0;
  bit            ended    = 0;

  meas_top #(.CNT_W(CW), .WIN_LEN(WIN)) u_dut (
    .clk_main(clk_main), .clk_slow(clk_slow), .rst_n(rst_n),
    .start(start), .result(result), .ready(ready)
  );

  // 50 MHz main clock; when halted it parks low.
  always #10 if (clk_run || clk_main) clk_main = ~clk_main;

  // Slow clock: period is kdiv main periods, edges offset by 3 ns.
  initial begin
    #3;
    forever #(10 * kdiv) clk_slow = ~clk_slow;
  end

  function automatic int expect_cnt(input int k);
    int v;
    v = WIN * k;
    return (v > TOPV) ? TOPV : v;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // Start pulse for one main cycle, then check the flag at the next negedge.
  task automatic pulse_start(input bit check_clear);
    @(negedge clk_main);
    start = 1'b1;
    @(negedge clk_main);
    start = 1'b0;
    if (check_clear) check(ready == 1'b0, "R5 ready cleared by start", int'(ready), 0);
  endtask

  task automatic wait_ready(output bit got);
    got = 0;
    for (int i = 0; i < 60 * kdiv + 200; i++) begin
      @(negedge clk_main);
      if (ready) begin
        got = 1;
        break;
      end
    end
  endtask

  initial begin
    #2_000_000;
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    bit got;
    int prev;
    // R1: reset state
    repeat (5) @(negedge clk_main);
    check(ready == 1'b0, "R1 ready in reset", int'(ready), 0);
    check(result == '0, "R1 result in reset", int'(result), 0);
    rst_n = 1'b1;
    @(negedge clk_main);
    check(ready == 1'b0 && result == '0, "R1 state after release", int'(result), 0);

    // R2: measurement without a start pulse
    wait_ready(got);
    check(got, "R2 ready after reset release", int'(got), 1);
    check(int'(result) == expect_cnt(kdiv), "R2 first result", int'(result), expect_cnt(kdiv));

    // R3 / R4 / R7: sweep of slow-to-main ratios
    for (int k = 2; k <= 18; k++) begin
      kdiv = k;
      repeat (3 * 20) @(negedge clk_main);
      prev = int'(result);
      pulse_start(1'b1);
      check(int'(result) == prev, "R5 result held after start", int'(result), prev);
      wait_ready(got);
      if (expect_cnt(k) == TOPV)
        check(got && int'(result) == TOPV, "R4 saturated count", int'(result), TOPV);
      else
        check(got && int'(result) == expect_cnt(k), "R3 R7 count at ready", int'(result), expect_cnt(k));
      repeat (4) @(negedge clk_main);
      check(ready && int'(result) == expect_cnt(k), "R6 result held while ready",
            int'(result), expect_cnt(k));
    end

    // R8: restart in the middle of an open window
    kdiv = 5;
    repeat (60) @(negedge clk_main);
    pulse_start(1'b1);
    repeat (6 * 5) @(negedge clk_main);
    check(ready == 1'b0, "R8 no ready mid window", int'(ready), 0);
    pulse_start(1'b1);
    wait_ready(got);
    check(got && int'(result) == expect_cnt(5), "R8 full window after restart",
          int'(result), expect_cnt(5));

    // R9: main clock halted after a start
    prev = int'(result);
    kdiv = 6;
    repeat (60) @(negedge clk_main);
    pulse_start(1'b1);
    clk_run = 1'b0;
    #(40 * 20 * 6 * 20);
    check(ready == 1'b0, "R9 ready while main stopped", int'(ready), 0);
    check(int'(result) == prev, "R9 result while main stopped", int'(result), prev);
    clk_run = 1'b1;
    repeat (40 * 6) @(negedge clk_main);
    check(ready == 1'b0, "R9 ready after main resumes", int'(ready), 0);
    check(int'(result) == prev, "R9 result after main resumes", int'(result), prev);
    pulse_start(1'b1);
    wait_ready(got);
    check(got && int'(result) == expect_cnt(6), "R9 recovery measurement",
          int'(result), expect_cnt(6));

    finish_run();
  end
endmodule